// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of single-bit lock latches that two independent ports (left and right) use to claim shared resources. A port claims a latch by writing a zero to it and confirms the claim by reading it back. A zero read back means the port holds the lock. A one means the lock is free or the other side holds it. Each latch shows complementary values to the two sides while it is held. Only the holder can free it.

When the non-holding side writes a zero while the latch is held, its request is queued. The queued side takes the lock in the same cycle that the holder frees it. When both sides claim a free latch in the same cycle, a fixed tie-break picks the winner, and the loser's request is queued. The latches sit apart from any memory array.

All accesses are synchronous to one clock. A write takes effect at the clock edge of its access cycle. A read captures the value into a per-port output register at the edge of its access cycle. That register holds until the same port reads again.

Top module: `dp_semaphore`

## Requirements
- R1: A latch is chosen by address bits [2:0] of the accessing port. The higher address bits have no effect on which latch is accessed.
- R2: A port accesses a latch only in a cycle where its semaphore select is low and its chip enable is high. In any other cycle the port's inputs change no latch and no output.
- R3: A write (rw_i low) uses the single data-in bit. Data-in 0 requests the latch, and data-in 1 releases the latch or cancels a pending request.
- R4: When a port requests a free latch, that port then reads 0 and the other port reads 1 at the same latch.
- R5: When the holder writes 1 and no request is pending, the latch becomes free and both ports read 1.
- R6: Suppose the non-holder writes 0 while the latch is held. That request is queued, and the non-holder becomes holder at the edge where the holder releases. If the non-holder writes 1 before the release, the queued request is cancelled.
- R7: A read (rw_i high, oe_ni low) captures the port's view into an output register and drives it on all DATA_W data lines (0x0000 or 0xFFFF at the default width). The register holds its value until that port reads again, even when the latch changes or oe_ni is high.
- R8: When both ports request the same free latch in the same cycle, the left port wins by default (TIE_LEFT=1). The right port's request is queued.
- R9: After reset, all latches are free and no request is pending. Both data-out buses read all ones.
- R10: A write of 1 by a port that neither holds the latch nor has a request pending on it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sem_ni | input | 1 | Left semaphore select, active low |
| l_ce_ni | input | 1 | Left memory chip enable, active low; must be high during a semaphore access |
| l_addr_i | input | BUS_ADDR_W | Left address; low bits select the latch |
| l_rw_i | input | 1 | Left direction: 1 read, 0 write |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_din_i | input | 1 | Left write data bit |
| l_dout_o | output | DATA_W | Left captured read value |
| r_sem_ni | input | 1 | Right semaphore select, active low |
| r_ce_ni | input | 1 | Right memory chip enable, active low |
| r_addr_i | input | BUS_ADDR_W | Right address |
| r_rw_i | input | 1 | Right direction: 1 read, 0 write |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_din_i | input | 1 | Right write data bit |
| r_dout_o | output | DATA_W | Right captured read value |

## Verification
The hardest cases to reach are the two that need both ports active around the same latch. One is a same-cycle request from both sides. The other is a queued request that becomes ownership exactly at the holder's release. The bench drives both ports from one task in a single cycle to create the tie. It then builds the hand-off in order: one side takes the latch, the other side queues, and the holder releases. Reads bracket each step. One stale read, taken before the hand-off and re-checked after it, shows that the output register does not follow the latch.

// File: rtl/dp_sem_pkg.sv
package dp_sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/dp_sem_port.sv
module dp_sem_port #(
  parameter int NUM_SEM    = 8,
  parameter int BUS_ADDR_W = 15,
  parameter int DATA_W     = 16,
  localparam int IDX_W     = $clog2(NUM_SEM)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sem_ni,
  input  logic               ce_ni,
  input  logic [BUS_ADDR_W-1:0] addr_i,
  input  logic               rw_i,
  input  logic               oe_ni,
  input  logic               din_i,
  input  logic [NUM_SEM-1:0] view_i,
  output logic [NUM_SEM-1:0] req_o,
  output logic [NUM_SEM-1:0] rel_o,
  output logic               rd_o,
  output logic [DATA_W-1:0]  dout_o
);
  logic             acc;
  logic             wr;
  logic [IDX_W-1:0] idx;

  assign acc  = ~sem_ni & ce_ni;
  assign wr   = acc & ~rw_i;
  assign rd_o = acc & rw_i & ~oe_ni;
  assign idx  = addr_i[IDX_W-1:0];

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
    assign req_o[i] = wr & (idx == IDX_W'(i)) & ~din_i;
    assign rel_o[i] = wr & (idx == IDX_W'(i)) &  din_i;
  end

  // output register: holds until this port reads again
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_o <= '1;
    else if (rd_o) dout_o <= {DATA_W{view_i[idx]}};
  end
endmodule

// File: rtl/dp_sem_cell.sv
module dp_sem_cell #(
  parameter bit TIE_LEFT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output logic view_l_o,
  output logic view_r_o
);
  import dp_sem_pkg::*;

  sem_owner_e own_q, own_d;
  logic       pend_l_q, pend_l_d;
  logic       pend_r_q, pend_r_d;

  always_comb begin
    own_d    = own_q;
    pend_l_d = pend_l_q;
    pend_r_d = pend_r_q;
    unique case (own_q)
      OWN_NONE: begin
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
        if (req_l_i && req_r_i) begin
          if (TIE_LEFT) begin own_d = OWN_LEFT;  pend_r_d = 1'b1; end
          else          begin own_d = OWN_RIGHT; pend_l_d = 1'b1; end
        end else if (req_l_i) begin
          own_d = OWN_LEFT;
        end else if (req_r_i) begin
          own_d = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        pend_l_d = 1'b0;
        if (req_r_i) pend_r_d = 1'b1;
        if (rel_r_i) pend_r_d = 1'b0;
        if (rel_l_i) begin
          own_d    = pend_r_d ? OWN_RIGHT : OWN_NONE;
          pend_r_d = 1'b0;
        end
      end
      OWN_RIGHT: begin
        pend_r_d = 1'b0;
        if (req_l_i) pend_l_d = 1'b1;
        if (rel_l_i) pend_l_d = 1'b0;
        if (rel_r_i) begin
          own_d    = pend_l_d ? OWN_LEFT : OWN_NONE;
          pend_l_d = 1'b0;
        end
      end
      default: begin
        own_d    = OWN_NONE;
        pend_l_d = 1'b0;
        pend_r_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q    <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      own_q    <= own_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign view_l_o = (own_q != OWN_LEFT);
  assign view_r_o = (own_q != OWN_RIGHT);
endmodule

// File: rtl/dp_semaphore.sv
module dp_semaphore #(
  parameter int NUM_SEM    = 8,
  parameter int BUS_ADDR_W = 15,
  parameter int DATA_W     = 16,
  parameter bit TIE_LEFT   = 1'b1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  l_sem_ni,
  input  logic                  l_ce_ni,
  input  logic [BUS_ADDR_W-1:0] l_addr_i,
  input  logic                  l_rw_i,
  input  logic                  l_oe_ni,
  input  logic                  l_din_i,
  output logic [DATA_W-1:0]     l_dout_o,
  input  logic                  r_sem_ni,
  input  logic                  r_ce_ni,
  input  logic [BUS_ADDR_W-1:0] r_addr_i,
  input  logic                  r_rw_i,
  input  logic                  r_oe_ni,
  input  logic                  r_din_i,
  output logic [DATA_W-1:0]     r_dout_o
);
  logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
  logic [NUM_SEM-1:0] l_view, r_view;
  logic               l_rd, r_rd;

  dp_sem_port #(.NUM_SEM(NUM_SEM), .BUS_ADDR_W(BUS_ADDR_W), .DATA_W(DATA_W)) u_port_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .sem_ni(l_sem_ni), .ce_ni(l_ce_ni),
    .addr_i(l_addr_i), .rw_i(l_rw_i), .oe_ni(l_oe_ni), .din_i(l_din_i),
    .view_i(l_view), .req_o(l_req), .rel_o(l_rel), .rd_o(l_rd), .dout_o(l_dout_o)
  );

  dp_sem_port #(.NUM_SEM(NUM_SEM), .BUS_ADDR_W(BUS_ADDR_W), .DATA_W(DATA_W)) u_port_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .sem_ni(r_sem_ni), .ce_ni(r_ce_ni),
    .addr_i(r_addr_i), .rw_i(r_rw_i), .oe_ni(r_oe_ni), .din_i(r_din_i),
    .view_i(r_view), .req_o(r_req), .rel_o(r_rel), .rd_o(r_rd), .dout_o(r_dout_o)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    dp_sem_cell #(.TIE_LEFT(TIE_LEFT)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .req_l_i(l_req[i]), .rel_l_i(l_rel[i]),
      .req_r_i(r_req[i]), .rel_r_i(r_rel[i]),
      .view_l_o(l_view[i]), .view_r_o(r_view[i])
    );
  end
endmodule

// File: rtl/dp_semaphore_chk.sv
module dp_semaphore_chk #(
  parameter int NUM_SEM = 8,
  parameter int DATA_W  = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SEM-1:0] l_view,
  input logic [NUM_SEM-1:0] r_view,
  input logic [NUM_SEM-1:0] l_rel,
  input logic [NUM_SEM-1:0] r_rel,
  input logic               l_rd,
  input logic               r_rd,
  input logic [DATA_W-1:0]  l_dout_o,
  input logic [DATA_W-1:0]  r_dout_o
);
  AST_VIEW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_view | r_view) == '1); // R4

  AST_L_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_rd |=> $stable(l_dout_o)); // R7

  AST_R_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_rd |=> $stable(r_dout_o)); // R7

  AST_L_DOUT_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_dout_o == '0) || (l_dout_o == '1)); // R7

  AST_R_DOUT_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_dout_o == '0) || (r_dout_o == '1)); // R7

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_own
    AST_L_KEEPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!l_view[i] && !l_rel[i]) |=> !l_view[i]); // R5

    AST_R_KEEPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!r_view[i] && !r_rel[i]) |=> !r_view[i]); // R5
  end
endmodule

bind dp_semaphore dp_semaphore_chk #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_view(l_view), .r_view(r_view), .l_rel(l_rel), .r_rel(r_rel),
  .l_rd(l_rd), .r_rd(r_rd), .l_dout_o(l_dout_o), .r_dout_o(r_dout_o)
);

// File: tb/dp_semaphore_tb.sv
module dp_semaphore_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 16;
  localparam logic [DW-1:0] ONES  = '1;
  localparam logic [DW-1:0] ZEROS = '0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sem_n = 1'b1, l_ce_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1, l_din = 1'b1;
  logic r_sem_n = 1'b1, r_ce_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1, r_din = 1'b1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_dout, r_dout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    bit            side;
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_semaphore u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sem_ni(l_sem_n), .l_ce_ni(l_ce_n), .l_addr_i(l_addr), .l_rw_i(l_rw),
    .l_oe_ni(l_oe_n), .l_din_i(l_din), .l_dout_o(l_dout),
    .r_sem_ni(r_sem_n), .r_ce_ni(r_ce_n), .r_addr_i(r_addr), .r_rw_i(r_rw),
    .r_oe_ni(r_oe_n), .r_din_i(r_din), .r_dout_o(r_dout)
  );

  task automatic idle();
    l_sem_n = 1'b1; l_ce_n = 1'b1; l_rw = 1'b1; l_oe_n = 1'b1;
    r_sem_n = 1'b1; r_ce_n = 1'b1; r_rw = 1'b1; r_oe_n = 1'b1;
  endtask

  task automatic drive(input bit side, input int addr, input bit rw, input bit d,
                       input bit ce_n, input bit oe_n);
    if (!side) begin
      l_sem_n = 1'b0; l_ce_n = ce_n; l_addr = AW'(addr); l_rw = rw; l_din = d; l_oe_n = oe_n;
    end else begin
      r_sem_n = 1'b0; r_ce_n = ce_n; r_addr = AW'(addr); r_rw = rw; r_din = d; r_oe_n = oe_n;
    end
  endtask

  task automatic wr(input bit side, input int addr, input bit d, input bit ce_n = 1'b1);
    @(negedge clk);
    drive(side, addr, 1'b0, d, ce_n, 1'b1);
    @(negedge clk);
    idle();
  endtask

  task automatic wr_both(input int addr, input bit dl, input bit dr);
    @(negedge clk);
    drive(1'b0, addr, 1'b0, dl, 1'b1, 1'b1);
    drive(1'b1, addr, 1'b0, dr, 1'b1, 1'b1);
    @(negedge clk);
    idle();
  endtask

  // read cycle; expected value pushed for the monitor after the capture edge
  task automatic rd(input bit side, input int addr, input logic [DW-1:0] exp,
                    input string tag, input bit oe_n = 1'b0);
    item_t it;
    @(negedge clk);
    drive(side, addr, 1'b1, 1'b1, 1'b1, oe_n);
    @(negedge clk);
    idle();
    it.side = side; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [DW-1:0] act;
        it = sb_q.pop_front();
        act = it.side ? r_dout : l_dout;
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s port=%s actual=%h expected=%h", it.tag,
                   it.side ? "right" : "left", act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    item_t it;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state of both output registers
    it.side = 1'b0; it.exp = ONES; it.tag = "R9"; sb_q.push_back(it);
    it.side = 1'b1; it.exp = ONES; it.tag = "R9"; sb_q.push_back(it);
    rd(1'b0, 0, ONES, "R9");
    rd(1'b1, 0, ONES, "R9");

    // R3 R4: left takes free latch 2
    wr(1'b0, 2, 1'b0);
    rd(1'b0, 2, ZEROS, "R4");
    rd(1'b1, 2, ONES, "R4");
    // R1: high address bits ignored
    rd(1'b1, 15'h7FF2, ONES, "R1");
    rd(1'b0, 15'h5A42, ZEROS, "R1");

    // R6: right queues, left releases, right owns
    wr(1'b1, 2, 1'b0);
    rd(1'b1, 2, ONES, "R6");
    wr(1'b0, 2, 1'b1);
    rd(1'b1, 2, ZEROS, "R6");
    rd(1'b0, 2, ONES, "R6");

    // R10: left writes one without holding or queuing
    wr(1'b0, 2, 1'b1);
    rd(1'b1, 2, ZEROS, "R10");
    // R5: holder frees latch
    wr(1'b1, 2, 1'b1);
    rd(1'b0, 2, ONES, "R5");
    rd(1'b1, 2, ONES, "R5");

    // R2: chip enable active blocks the access
    wr(1'b0, 3, 1'b0, 1'b0);
    rd(1'b0, 3, ONES, "R2");
    rd(1'b1, 3, ONES, "R2");

    // R8: same-cycle request, left wins, right queued
    wr_both(5, 1'b0, 1'b0);
    rd(1'b0, 5, ZEROS, "R8");
    rd(1'b1, 5, ONES, "R8");
    wr(1'b0, 5, 1'b1);
    rd(1'b1, 5, ZEROS, "R8");
    rd(1'b0, 5, ONES, "R8");
    wr(1'b1, 5, 1'b1);

    // R6: cancelled request does not take over
    wr(1'b0, 6, 1'b0);
    wr(1'b1, 6, 1'b0);
    wr(1'b1, 6, 1'b1);
    wr(1'b0, 6, 1'b1);
    rd(1'b0, 6, ONES, "R6");
    rd(1'b1, 6, ONES, "R6");

    // R7: captured value survives a hand-off and an oe-high read
    wr(1'b1, 7, 1'b0);
    wr(1'b0, 7, 1'b0);
    rd(1'b0, 7, ONES, "R7");
    wr(1'b1, 7, 1'b1);
    rd(1'b0, 7, ONES, "R7", 1'b1);
    rd(1'b0, 7, ZEROS, "R7");
    rd(1'b1, 7, ONES, "R7");
    wr(1'b0, 7, 1'b1);
    rd(1'b1, 7, ONES, "R5");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule